// File: doc/BRIEF.md
# Colour Gain/Offset Rotation Sequencer

This block sits in front of a colour line-scanner front end and decides, at every pixel or every line, which colour input (red, green or blue) the input multiplexer passes on and which of the three stored gain and offset codes drive the gain stage and offset converter. A 2-bit signal configuration picks one of four behaviours. These are: fixed red; red input with gain and offset cycling per pixel; input, gain and offset cycling together per pixel; and input, gain and offset cycling once per line.

All logic runs on one system clock. The falling edge of the pixel sample clock reaches the block as the one-cycle strobe `pix_fall`. The line-start signal `line_sync` is a level. `mode_wr` marks a write of the mode register, and `sig_cfg` is the configuration carried by that register. Two state machines hold the colour. The pixel machine has the states PX_RED, PX_GRN and PX_BLU, with transitions ADVANCE (on a pixel strobe), SYNC_HOLD (line start forces red) and FIXED (modes that do not rotate per pixel). The line machine has the states LN_PARK, LN_RED, LN_GRN and LN_BLU, with transitions ADVANCE (on a rising `line_sync` in line mode) and PARK (on a mode write with line configuration).

The outputs are registered. They are reloaded only on a load event: a pixel strobe, `line_sync` high, or a mode write. When a code changes between load events, the outputs do not move until the next colour boundary.

Top module: `rgb_rot_seq`

## Requirements
- R1: With `sig_cfg`=0, every load event sets `mux_sel` to red and `gain_act`/`offs_act` to the red codes.
- R2: With `sig_cfg`=1, `mux_sel` stays red while the codes presented step red, green, blue, red on each `pix_fall` with `line_sync` low.
- R3: With `sig_cfg`=2, `mux_sel` and the codes step together red, green, blue, red on each `pix_fall` with `line_sync` low.
- R4: With `sig_cfg`=3, each rising `line_sync` moves the line colour one step: parked to red, red to green, green to blue, blue to red. `mux_sel` and the codes follow the line colour, and a parked line shows red.
- R5: In configurations 1 and 2, `line_sync` high forces the pixel colour to red in the next cycle, and any `pix_fall` in that cycle is ignored.
- R6: A `mode_wr` with `sig_cfg`=3 parks the line rotation, so the next rising `line_sync` starts at red. If the write and the rising edge come in the same cycle, the write wins and that edge is consumed.
- R7: `sim_sample` pulses for one cycle after a `pix_fall` taken in configuration 2 with `line_sync` low while the pixel colour is red. This happens on every third pixel strobe, and never in any other configuration.
- R8: The colour encoding is red=0, green=1, blue=2 on `mux_sel`. The code buses pack red in the least significant field, then green, then blue (`gain_codes[5:0]` red, `[11:6]` green, `[17:12]` blue, and the same 8-bit slots for offsets).
- R9: Reset clears `mux_sel`, `gain_act`, `offs_act` and `sim_sample` to zero. Outside load events the three colour outputs hold, even when the stored codes or `sig_cfg` change.
- R10: A `mode_wr` with a configuration other than 3 leaves the line rotation where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_fall | input | 1 | One-cycle strobe at each falling edge of the sample clock |
| line_sync | input | 1 | Line-start level |
| mode_wr | input | 1 | One-cycle strobe on a mode-register write |
| sig_cfg | input | 2 | Signal configuration 0..3 |
| gain_codes | input | 18 | Stored gain codes {blue, green, red} |
| offs_codes | input | 24 | Stored offset codes {blue, green, red} |
| mux_sel | output | 2 | Input multiplexer colour select |
| gain_act | output | 6 | Active gain code |
| offs_act | output | 8 | Active offset code |
| sim_sample | output | 1 | Simultaneous three-input sample strobe |

## Verification
Two events can land in the same cycle: a mode write that parks the line rotation, and a rising `line_sync` that would advance it. The bench drives both in one cycle in line mode and expects red on the outputs. It also expects the following rising edge to give red again rather than green. A second collision pairs `line_sync` high with a pixel strobe in the pixel modes, where the sync must win and the strobe must neither advance the colour nor raise `sim_sample`. The bench judges every cycle against a behavioural model that receives the same stimulus.

// File: rtl/rgb_rot_pkg.sv
package rgb_rot_pkg;

    typedef enum logic [1:0] {
        COL_RED = 2'd0,
        COL_GRN = 2'd1,
        COL_BLU = 2'd2
    } colour_t;

    typedef enum logic [1:0] {
        CFG_MONO    = 2'd0,
        CFG_GAINROT = 2'd1,
        CFG_PIXROT  = 2'd2,
        CFG_LINEROT = 2'd3
    } cfg_t;

    typedef enum logic [1:0] {
        LN_PARK = 2'd0,
        LN_RED  = 2'd1,
        LN_GRN  = 2'd2,
        LN_BLU  = 2'd3
    } line_t;

    localparam int unsigned NUM_COL = 3;

    function automatic colour_t col_next(input colour_t c);
        case (c)
            COL_RED: return COL_GRN;
            COL_GRN: return COL_BLU;
            default: return COL_RED;
        endcase
    endfunction

endpackage

// File: rtl/rgb_pix_fsm.sv
module rgb_pix_fsm
    import rgb_rot_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cfg_t    cfg,
    input  logic    sync,
    input  logic    pix_fall,
    output colour_t nxt_col,
    output logic    sim_hit
);

    colour_t state;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= COL_RED;
        else        state <= nxt_col;
    end

    // transitions: FIXED, SYNC_HOLD, ADVANCE
    always_comb begin
        nxt_col = state;
        sim_hit = 1'b0;
        unique case (cfg)
            CFG_MONO, CFG_LINEROT: begin
                nxt_col = COL_RED;                  // FIXED
            end
            CFG_GAINROT, CFG_PIXROT: begin
                if (sync) begin
                    nxt_col = COL_RED;              // SYNC_HOLD
                end else if (pix_fall) begin
                    nxt_col = col_next(state);      // ADVANCE
                    sim_hit = (cfg == CFG_PIXROT) && (state == COL_RED);
                end
            end
        endcase
    end

endmodule

// File: rtl/rgb_line_fsm.sv
module rgb_line_fsm
    import rgb_rot_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cfg_t    cfg,
    input  logic    sync,
    input  logic    mode_wr,
    output colour_t nxt_col
);

    line_t state;
    line_t nxt;
    logic  sync_d;
    logic  rise;

    assign rise = sync && !sync_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LN_PARK;
            sync_d <= 1'b0;
        end else begin
            state  <= nxt;
            sync_d <= sync;
        end
    end

    // transitions: PARK, ADVANCE
    always_comb begin
        nxt = state;
        if (cfg == CFG_LINEROT) begin
            if (mode_wr) begin
                nxt = LN_PARK;                      // PARK wins over ADVANCE
            end else if (rise) begin
                unique case (state)
                    LN_PARK: nxt = LN_RED;
                    LN_RED:  nxt = LN_GRN;
                    LN_GRN:  nxt = LN_BLU;
                    LN_BLU:  nxt = LN_RED;
                endcase
            end
        end
    end

    // colour seen for the coming line
    always_comb begin
        unique case (nxt)
            LN_GRN:  nxt_col = COL_GRN;
            LN_BLU:  nxt_col = COL_BLU;
            default: nxt_col = COL_RED;
        endcase
    end

endmodule

// File: rtl/rgb_code_sel.sv
module rgb_code_sel
    import rgb_rot_pkg::*;
#(
    parameter int unsigned W = 6
) (
    input  logic [NUM_COL*W-1:0] codes,
    input  colour_t              col,
    output logic [W-1:0]         code
);

    logic [W-1:0] slot [NUM_COL];

    for (genvar i = 0; i < NUM_COL; i++) begin : g_slot
        assign slot[i] = codes[i*W +: W];
    end

    always_comb begin
        unique case (col)
            COL_GRN: code = slot[1];
            COL_BLU: code = slot[2];
            default: code = slot[0];
        endcase
    end

endmodule

// File: rtl/rgb_rot_seq.sv
module rgb_rot_seq
    import rgb_rot_pkg::*;
#(
    parameter int unsigned GAIN_W = 6,
    parameter int unsigned OFFS_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pix_fall,
    input  logic                      line_sync,
    input  logic                      mode_wr,
    input  logic [1:0]                sig_cfg,
    input  logic [NUM_COL*GAIN_W-1:0] gain_codes,
    input  logic [NUM_COL*OFFS_W-1:0] offs_codes,
    output logic [1:0]                mux_sel,
    output logic [GAIN_W-1:0]         gain_act,
    output logic [OFFS_W-1:0]         offs_act,
    output logic                      sim_sample
);

    cfg_t        cfg;
    colour_t     pix_col;
    colour_t     line_col;
    colour_t     code_col;
    colour_t     sel_col;
    logic        sim_hit;
    logic        load;
    logic [GAIN_W-1:0] gain_nxt;
    logic [OFFS_W-1:0] offs_nxt;

    assign cfg  = cfg_t'(sig_cfg);
    assign load = pix_fall || line_sync || mode_wr;

    rgb_pix_fsm u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .sync     (line_sync),
        .pix_fall (pix_fall),
        .nxt_col  (pix_col),
        .sim_hit  (sim_hit)
    );

    rgb_line_fsm u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .sync    (line_sync),
        .mode_wr (mode_wr),
        .nxt_col (line_col)
    );

    always_comb begin
        unique case (cfg)
            CFG_MONO:    begin code_col = COL_RED;  sel_col = COL_RED;  end
            CFG_GAINROT: begin code_col = pix_col;  sel_col = COL_RED;  end
            CFG_PIXROT:  begin code_col = pix_col;  sel_col = pix_col;  end
            CFG_LINEROT: begin code_col = line_col; sel_col = line_col; end
        endcase
    end

    rgb_code_sel #(.W(GAIN_W)) u_gsel (
        .codes (gain_codes),
        .col   (code_col),
        .code  (gain_nxt)
    );

    rgb_code_sel #(.W(OFFS_W)) u_osel (
        .codes (offs_codes),
        .col   (code_col),
        .code  (offs_nxt)
    );

    // output register: reloads only at colour boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_sel    <= '0;
            gain_act   <= '0;
            offs_act   <= '0;
            sim_sample <= 1'b0;
        end else begin
            sim_sample <= sim_hit;
            if (load) begin
                mux_sel  <= sel_col;
                gain_act <= gain_nxt;
                offs_act <= offs_nxt;
            end
        end
    end

endmodule

// File: rtl/rgb_rot_seq_chk.sv
module rgb_rot_seq_chk #(
    parameter int unsigned GAIN_W = 6,
    parameter int unsigned OFFS_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pix_fall,
    input logic                line_sync,
    input logic                mode_wr,
    input logic [1:0]          sig_cfg,
    input logic [3*GAIN_W-1:0] gain_codes,
    input logic [3*OFFS_W-1:0] offs_codes,
    input logic [1:0]          mux_sel,
    input logic [GAIN_W-1:0]   gain_act,
    input logic [OFFS_W-1:0]   offs_act,
    input logic                sim_sample
);

    AST_MONO_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_cfg == 2'd0 && (pix_fall || line_sync || mode_wr))
        |=> (mux_sel == 2'd0 && gain_act == $past(gain_codes[GAIN_W-1:0])
             && offs_act == $past(offs_codes[OFFS_W-1:0]))); // R1

    AST_GAINROT_SEL_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_cfg == 2'd1 && (pix_fall || line_sync || mode_wr)) |=> (mux_sel == 2'd0)); // R2

    AST_SYNC_FORCES_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sync && sig_cfg != 2'd3) |=> (mux_sel == 2'd0 && !sim_sample)); // R5

    AST_PARK_SHOWS_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && sig_cfg == 2'd3) |=> (mux_sel == 2'd0)); // R6

    AST_SIM_PIXMODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!(pix_fall && sig_cfg == 2'd2)) |=> !sim_sample); // R7

    AST_SIM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sim_sample |=> !sim_sample); // R7

    AST_HOLD_BETWEEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_fall || line_sync || mode_wr)
        |=> ($stable(mux_sel) && $stable(gain_act) && $stable(offs_act))); // R9

endmodule

bind rgb_rot_seq rgb_rot_seq_chk #(.GAIN_W(GAIN_W), .OFFS_W(OFFS_W)) u_chk (.*);

// File: tb/rgb_rot_seq_bench.sv
module rgb_rot_seq_bench;

    localparam int GW = 6;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_fall = 1'b0;
    logic          line_sync = 1'b0;
    logic          mode_wr = 1'b0;
    logic [1:0]    sig_cfg = 2'd0;
    logic [3*GW-1:0] gain_codes = '0;
    logic [3*OW-1:0] offs_codes = '0;
    logic [1:0]    mux_sel;
    logic [GW-1:0] gain_act;
    logic [OW-1:0] offs_act;
    logic          sim_sample;

    int total = 0;
    int bad = 0;
    bit armed = 0;
    bit finished = 0;
    string tag = "R9";

    // behavioural reference state
    int m_pc = 0;
    int m_lc = -1;
    bit m_ps = 0;
    int e_sel = 0;
    int e_g = 0;
    int e_o = 0;
    bit e_sim = 0;

    always #10 clk = ~clk;   // 50 MHz

    rgb_rot_seq #(.GAIN_W(GW), .OFFS_W(OW)) u_rgb_rot_seq (.*);

    function automatic int gcode(int c);
        return int'(gain_codes[c*GW +: GW]);
    endfunction

    function automatic int ocode(int c);
        return int'(offs_codes[c*OW +: OW]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_lc = -1; m_ps = 0;
            e_sel = 0; e_g = 0; e_o = 0; e_sim = 0;
        end else begin
            int cfgv;
            int npc;
            int nlc;
            int cc;
            cfgv = int'(sig_cfg);
            e_sim = (cfgv == 2) && pix_fall && !line_sync && (m_pc == 0);
            if (cfgv == 0 || cfgv == 3) npc = 0;
            else if (line_sync)         npc = 0;
            else if (pix_fall)          npc = (m_pc + 1) % 3;
            else                        npc = m_pc;
            nlc = m_lc;
            if (cfgv == 3) begin
                if (mode_wr)                  nlc = -1;
                else if (line_sync && !m_ps)  nlc = (m_lc + 1) % 3;
            end
            if (pix_fall || line_sync || mode_wr) begin
                if (cfgv == 0)      cc = 0;
                else if (cfgv == 3) cc = (nlc < 0) ? 0 : nlc;
                else                cc = npc;
                e_sel = (cfgv == 2 || cfgv == 3) ? cc : 0;
                e_g = gcode(cc);
                e_o = ocode(cc);
            end
            m_pc = npc; m_lc = nlc; m_ps = line_sync;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !finished) begin
            check(int'(mux_sel) == e_sel, tag, "mux_sel", int'(mux_sel), e_sel);
            check(int'(gain_act) == e_g, tag, "gain_act", int'(gain_act), e_g);
            check(int'(offs_act) == e_o, tag, "offs_act", int'(offs_act), e_o);
            check(sim_sample == e_sim, (tag == "R3") ? "R7" : tag, "sim_sample",
                  int'(sim_sample), int'(e_sim));
        end
    end

    task automatic step(input bit pf, input bit sy, input bit mw);
        pix_fall = pf; line_sync = sy; mode_wr = mw;
        @(negedge clk);
    endtask

    task automatic new_codes();
        gain_codes = {GW'($urandom), GW'($urandom), GW'($urandom)};
        offs_codes = {OW'($urandom), OW'($urandom), OW'($urandom)};
    endtask

    task automatic burst(input int n, input int cfgv, input int sy_pct, input int mw_pct);
        sig_cfg = 2'(cfgv);
        for (int i = 0; i < n; i++) begin
            if ($urandom % 10 == 0) new_codes();
            step(bit'($urandom % 2), bit'(($urandom % 100) < sy_pct),
                 bit'(($urandom % 100) < mw_pct));
        end
    endtask

    task automatic finish_up();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_up();
    end

    initial begin
        new_codes();
        repeat (3) @(negedge clk);
        // R9: reset state
        check(mux_sel == 2'd0 && gain_act == '0 && offs_act == '0 && !sim_sample,
              "R9", "reset outputs", int'(gain_act) + int'(offs_act), 0);
        rst_n = 1'b1;
        armed = 1;
        @(negedge clk);

        tag = "R1"; burst(300, 0, 10, 5);
        tag = "R2"; burst(300, 1, 5, 5);
        tag = "R3"; burst(400, 2, 5, 3);
        // R8: distinct known codes, clean pixel rotation
        tag = "R8";
        gain_codes = {6'd33, 6'd22, 6'd11};
        offs_codes = {8'd203, 8'd102, 8'd101};
        sig_cfg = 2'd2;
        step(0, 1, 0);
        for (int i = 0; i < 7; i++) step(1, 0, 0);
        // R5: sync collides with pixel strobes
        tag = "R5";
        for (int i = 0; i < 40; i++) step(1, bit'(i % 3 == 1), 0);
        burst(200, 1, 40, 0);
        // R4: line rotation
        tag = "R4";
        sig_cfg = 2'd3;
        step(0, 0, 1);
        for (int i = 0; i < 8; i++) begin
            step(0, 1, 0); step(0, 1, 0); step(1, 0, 0); step(1, 0, 0);
        end
        burst(300, 3, 20, 0);
        // R6: park and rising sync in the same cycle
        tag = "R6";
        step(0, 0, 0);
        step(0, 1, 0); step(0, 0, 0);
        step(0, 1, 1); step(0, 0, 0);
        step(0, 1, 0); step(1, 0, 0);
        step(0, 1, 0); step(1, 0, 0);
        burst(200, 3, 20, 10);
        // R10: mode write in another configuration keeps the line state
        tag = "R10";
        sig_cfg = 2'd3; step(0, 0, 1);
        step(0, 1, 0); step(0, 0, 0);
        step(0, 1, 0); step(0, 0, 0);
        sig_cfg = 2'd2; step(0, 0, 1); step(1, 0, 1);
        sig_cfg = 2'd3; step(0, 0, 0);
        step(0, 1, 0); step(0, 0, 0);
        // R9: codes and configuration change without a load event
        tag = "R9";
        for (int i = 0; i < 30; i++) begin
            new_codes();
            sig_cfg = 2'($urandom);
            step(0, 0, 0);
        end
        tag = "R3"; burst(300, 2, 3, 2);
        tag = "R2"; burst(200, 1, 3, 2);
        finish_up();
    end

endmodule